// File: doc/BRIEF.md
# Big-Endian Byte-Addressed Data Memory

This block is the data store of a 32-bit processor. It keeps a parameterised number of 32-bit words and is reached through a byte address that the execute stage has already formed. Each request names one of four access kinds: full-word load, full-word store, single-byte load and single-byte store. Within a word the bytes are numbered big-endian. The lowest byte address of a word selects its most significant byte.

A byte store changes only the one addressed byte and keeps the other three bytes of that word. A byte load returns its byte sign-extended to the register width. A word access whose address is not a multiple of four is refused: the block raises an error flag and leaves storage untouched. Load results are registered and appear one cycle after the request. The word index wraps modulo the configured depth, which must be a power of two.

Top module: `be_data_mem`

## Requirements
- R1: A word store (op code 35 = load word, 43 = store word) at an address with low bits 00 writes all 32 bits. A later word load from the same address returns them unchanged.
- R2: A byte load (op code 32) from address 4k+b returns the byte held in bits [31-8b:24-8b] of word k. Offset 0 is the most significant byte and offset 3 is bits 7:0.
- R3: A byte store (op code 40) writes wdata[7:0] into the addressed byte only. The other three bytes of the word keep their previous contents.
- R4: A byte load sign-extends its byte: bits 31:8 of rdata all equal bit 7.
- R5: A word load or store whose address has nonzero low two bits raises `misalign` in the following cycle, writes nothing, keeps `rvalid` low and leaves `rdata` unchanged.
- R6: Byte accesses are accepted at every offset and never raise `misalign`.
- R7: `rvalid` is high exactly in the cycle after an accepted load request. `rdata` holds the last load result until the next accepted load, and a store in the cycle after a load does not alter the value returned by that load.
- R8: Address bits above the configured word index are ignored, so address A and address A + 4*DEPTH_WORDS reach the same word.
- R9: With `req` low, or with any op code other than 32, 35, 40 or 43, memory, `rvalid` and `misalign` are unaffected.
- R10: During reset `rvalid` and `misalign` are 0 and `rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset of the output registers |
| req | input | 1 | Access request strobe for this cycle |
| op | input | 6 | Access kind: 35 word load, 43 word store, 32 byte load, 40 byte store |
| addr | input | 32 | Byte address of the access |
| wdata | input | 32 | Store data; byte stores use bits 7:0 |
| rdata | output | 32 | Registered load result, sign-extended for byte loads |
| rvalid | output | 1 | High in the cycle after an accepted load |
| misalign | output | 1 | High in the cycle after a refused unaligned word access |

## Verification
Two things can occur in the same cycle: a load's registered result is presented while the next request, a store to that same word, is written into storage. The bench issues a word load and then, at once, a byte or word store to that word. It expects `rdata` to carry the pre-store contents while `rvalid` is high, and a following load to show the merged word. The bench also puts a refused unaligned store right after an accepted load. It checks that the error flag appears without disturbing the held read data, and that the word the store would have hit is unchanged.

// File: rtl/be_mem_pkg.sv
package be_mem_pkg;

  typedef enum logic [5:0] {
    OP_LB = 6'd32,
    OP_LW = 6'd35,
    OP_SB = 6'd40,
    OP_SW = 6'd43
  } mem_op_e;

  localparam int LANES  = 4;
  localparam int LANE_W = 8;
  localparam int WORD_W = LANES * LANE_W;

  // Big-endian lane select: offset 0 hits the most significant lane (lane 3).
  function automatic logic [LANES-1:0] lane_onehot(input logic [1:0] boff);
    logic [LANES-1:0] m;
    m = '0;
    m[LANES-1-boff] = 1'b1;
    return m;
  endfunction

  function automatic logic [LANE_W-1:0] pick_byte(input logic [WORD_W-1:0] w,
                                                 input logic [1:0] boff);
    logic [LANE_W-1:0] b;
    case (boff)
      2'd0:    b = w[31:24];
      2'd1:    b = w[23:16];
      2'd2:    b = w[15:8];
      default: b = w[7:0];
    endcase
    return b;
  endfunction

  function automatic logic [WORD_W-1:0] sext8(input logic [LANE_W-1:0] b);
    return {{(WORD_W-LANE_W){b[LANE_W-1]}}, b};
  endfunction

  function automatic logic is_word_op(input logic [5:0] o);
    return (o == OP_LW) || (o == OP_SW);
  endfunction

  function automatic logic is_byte_op(input logic [5:0] o);
    return (o == OP_LB) || (o == OP_SB);
  endfunction

endpackage

// File: rtl/be_mem_decode.sv
module be_mem_decode
  import be_mem_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             req,
  input  logic [5:0]       op,
  input  logic [31:0]      addr,
  output logic [IDX_W-1:0] word_idx,
  output logic [1:0]       boff,
  output logic [LANES-1:0] lane_we,
  output logic             ld_go,
  output logic             ld_byte,
  output logic             bad_align
);

  logic known_op;
  logic accept;
  logic unused_addr_hi;

  assign boff           = addr[1:0];
  assign word_idx       = addr[IDX_W+1:2];
  assign unused_addr_hi = ^addr[31:IDX_W+2];

  assign known_op  = is_word_op(op) || is_byte_op(op);
  assign bad_align = req && is_word_op(op) && (addr[1:0] != 2'b00);
  assign accept    = req && known_op && !bad_align;

  assign ld_go   = accept && ((op == OP_LW) || (op == OP_LB));
  assign ld_byte = (op == OP_LB);

  always_comb begin
    lane_we = '0;
    if (accept && op == OP_SW) lane_we = '1;
    else if (accept && op == OP_SB) lane_we = lane_onehot(boff);
  end

endmodule

// File: rtl/be_mem_array.sv
module be_mem_array
  import be_mem_pkg::*;
#(
  parameter int DEPTH_WORDS = 256,
  parameter int IDX_W       = $clog2(DEPTH_WORDS)
) (
  input  logic              clk,
  input  logic [LANES-1:0]  lane_we,
  input  logic [IDX_W-1:0]  word_idx,
  input  logic [WORD_W-1:0] lane_wdata,
  output logic [WORD_W-1:0] rword
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] store [DEPTH_WORDS];

    always_ff @(posedge clk) begin
      if (lane_we[g]) store[word_idx] <= lane_wdata[g*LANE_W +: LANE_W];
    end

    assign rword[g*LANE_W +: LANE_W] = store[word_idx];
  end

endmodule

// File: rtl/be_mem_rdfmt.sv
module be_mem_rdfmt
  import be_mem_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_go,
  input  logic              ld_byte,
  input  logic [1:0]        boff,
  input  logic              bad_align,
  input  logic [WORD_W-1:0] rword,
  output logic [WORD_W-1:0] rdata,
  output logic              rvalid,
  output logic              misalign
);

  logic [WORD_W-1:0] shaped;

  assign shaped = ld_byte ? sext8(pick_byte(rword, boff)) : rword;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata    <= '0;
      rvalid   <= 1'b0;
      misalign <= 1'b0;
    end else begin
      rvalid   <= ld_go;
      misalign <= bad_align;
      if (ld_go) rdata <= shaped;
    end
  end

endmodule

// File: rtl/be_data_mem.sv
module be_data_mem
  import be_mem_pkg::*;
#(
  parameter int DEPTH_WORDS = 256,
  localparam int IDX_W      = $clog2(DEPTH_WORDS)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req,
  input  logic [5:0]  op,
  input  logic [31:0] addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        rvalid,
  output logic        misalign
);

  // Named internal events, visible to the bound checker.
  logic [IDX_W-1:0]  word_idx;
  logic [1:0]        boff;
  logic [LANES-1:0]  lane_we;
  logic              ld_go;
  logic              ld_byte;
  logic              bad_align;
  logic [WORD_W-1:0] lane_wdata;
  logic [WORD_W-1:0] rword;

  assign lane_wdata = (op == OP_SB) ? {LANES{wdata[LANE_W-1:0]}} : wdata;

  be_mem_decode #(.IDX_W(IDX_W)) u_dec (
    .req       (req),
    .op        (op),
    .addr      (addr),
    .word_idx  (word_idx),
    .boff      (boff),
    .lane_we   (lane_we),
    .ld_go     (ld_go),
    .ld_byte   (ld_byte),
    .bad_align (bad_align)
  );

  be_mem_array #(.DEPTH_WORDS(DEPTH_WORDS), .IDX_W(IDX_W)) u_arr (
    .clk        (clk),
    .lane_we    (lane_we),
    .word_idx   (word_idx),
    .lane_wdata (lane_wdata),
    .rword      (rword)
  );

  be_mem_rdfmt u_fmt (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld_go     (ld_go),
    .ld_byte   (ld_byte),
    .boff      (boff),
    .bad_align (bad_align),
    .rword     (rword),
    .rdata     (rdata),
    .rvalid    (rvalid),
    .misalign  (misalign)
  );

endmodule

// File: rtl/be_data_mem_chk.sv
module be_data_mem_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req,
  input logic [5:0]  op,
  input logic [31:0] addr,
  input logic [31:0] rdata,
  input logic        rvalid,
  input logic        misalign,
  input logic [3:0]  lane_we
);

  logic word_req, byte_req, unaligned_word;
  assign word_req       = req && (op == 6'd35 || op == 6'd43);
  assign byte_req       = req && (op == 6'd32 || op == 6'd40);
  assign unaligned_word = word_req && (addr[1:0] != 2'b00);

  a_r5_no_write_on_misalign: assert property (@(posedge clk) disable iff (!rst_n)
    unaligned_word |-> lane_we == 4'b0000);

  a_r5_flag_next: assert property (@(posedge clk) disable iff (!rst_n)
    unaligned_word |=> (misalign && !rvalid));

  a_r3_byte_store_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
    (req && op == 6'd40) |-> $countones(lane_we) == 1);

  a_r1_word_store_all_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    (req && op == 6'd43 && addr[1:0] == 2'b00) |-> lane_we == 4'b1111);

  a_r9_idle_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    !req |-> lane_we == 4'b0000);

  a_r7_valid_next: assert property (@(posedge clk) disable iff (!rst_n)
    (req && (op == 6'd35 || op == 6'd32) && !unaligned_word) |=> rvalid);

  a_r7_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
    !rvalid |-> $stable(rdata));

  a_r4_sign_ext: assert property (@(posedge clk) disable iff (!rst_n)
    (req && op == 6'd32) |=> rdata[31:8] == {24{rdata[7]}});

  a_r6_byte_never_misaligned: assert property (@(posedge clk) disable iff (!rst_n)
    byte_req |=> !misalign);

endmodule

bind be_data_mem be_data_mem_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req      (req),
  .op       (op),
  .addr     (addr),
  .rdata    (rdata),
  .rvalid   (rvalid),
  .misalign (misalign),
  .lane_we  (lane_we)
);

// File: tb/be_data_mem_bench.sv
`timescale 1ns/1ps
module be_data_mem_bench;

  localparam int DEPTH = 256;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [5:0]  op = '0;
  logic [31:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rvalid;
  logic        misalign;

  always #2.5 clk = ~clk;

  be_data_mem #(.DEPTH_WORDS(DEPTH)) u_be_data_mem (
    .clk(clk), .rst_n(rst_n), .req(req), .op(op), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rvalid(rvalid), .misalign(misalign)
  );

  typedef struct {
    logic        rv;
    logic        mis;
    logic [31:0] rd;
    string       tag;
  } exp_t;

  exp_t        q[$];
  logic [31:0] mdl [int];
  logic [31:0] held_rd = '0;
  int          checks = 0;
  int          fails  = 0;
  bit          done   = 0;

  function automatic int widx(input logic [31:0] a);
    return int'((a >> 2) % DEPTH);
  endfunction

  function automatic logic [7:0] byte_of(input logic [31:0] w, input logic [1:0] o);
    logic [31:0] s;
    s = w >> (8 * (3 - int'(o)));
    return s[7:0];
  endfunction

  // Driver: applies one request and queues the outcome the requirements predict.
  task automatic access(input logic r, input logic [5:0] o, input logic [31:0] a,
                        input logic [31:0] d, input string tag);
    exp_t        e;
    logic [31:0] w;
    logic [7:0]  b;
    logic        wordop;
    @(negedge clk);
    req = r; op = o; addr = a; wdata = d;
    wordop = (o == 6'd35) || (o == 6'd43);
    e.rv = 1'b0; e.mis = 1'b0; e.tag = tag;
    if (r && wordop && a[1:0] != 2'b00) begin
      e.mis = 1'b1;
    end else if (r) begin
      w = mdl.exists(widx(a)) ? mdl[widx(a)] : 32'h0;
      case (o)
        6'd35: begin e.rv = 1'b1; held_rd = w; end
        6'd32: begin
          e.rv = 1'b1;
          b = byte_of(w, a[1:0]);
          held_rd = b[7] ? {24'hFFFFFF, b} : {24'h0, b};
        end
        6'd43: mdl[widx(a)] = d;
        6'd40: begin
          w[8*(3-int'(a[1:0])) +: 8] = d[7:0];
          mdl[widx(a)] = w;
        end
        default: ;
      endcase
    end
    e.rd = held_rd;
    q.push_back(e);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) access(1'b0, 6'd43, 32'h0, 32'hFFFF_FFFF, tag);
  endtask

  // Monitor: compares each cycle's result against the queued prediction.
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        e = q.pop_front();
        checks++;
        if (rvalid !== e.rv || misalign !== e.mis || rdata !== e.rd) begin
          fails++;
          $display("FAIL %s: actual rv=%0b mis=%0b rd=%h expected rv=%0b mis=%0b rd=%h",
                   e.tag, rvalid, misalign, rdata, e.rv, e.mis, e.rd);
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (rvalid !== 1'b0 || misalign !== 1'b0 || rdata !== 32'h0) begin
      fails++;
      $display("FAIL R10 reset: actual rv=%0b mis=%0b rd=%h expected 0 0 00000000",
               rvalid, misalign, rdata);
    end
    rst_n = 1'b1;

    // R1 word round trip
    access(1, 6'd43, 32'h0000_0000, 32'h1122_3344, "R1 store");
    access(1, 6'd35, 32'h0000_0000, 32'h0, "R1 load");
    // R2 big-endian byte order
    access(1, 6'd32, 32'h0000_0000, 32'h0, "R2 off0");
    access(1, 6'd32, 32'h0000_0001, 32'h0, "R2 off1");
    access(1, 6'd32, 32'h0000_0002, 32'h0, "R2 off2");
    access(1, 6'd32, 32'h0000_0003, 32'h0, "R2 off3");
    // R4 sign extension
    access(1, 6'd43, 32'h0000_0004, 32'h80FF_7F01, "R4 store");
    access(1, 6'd32, 32'h0000_0004, 32'h0, "R4 neg 80");
    access(1, 6'd32, 32'h0000_0005, 32'h0, "R4 neg FF");
    access(1, 6'd32, 32'h0000_0006, 32'h0, "R4 pos 7F");
    access(1, 6'd32, 32'h0000_0007, 32'h0, "R4 pos 01");
    // R3 byte merge, R6 odd offsets accepted
    access(1, 6'd43, 32'h0000_0008, 32'hDEAD_BEEF, "R3 base");
    access(1, 6'd40, 32'h0000_0009, 32'h1234_56AB, "R3 R6 sb off1");
    access(1, 6'd40, 32'h0000_000B, 32'hFFFF_FF5A, "R3 R6 sb off3");
    access(1, 6'd35, 32'h0000_0008, 32'h0, "R3 merged");
    // R7 same-word load then store back to back
    access(1, 6'd35, 32'h0000_0008, 32'h0, "R7 load before store");
    access(1, 6'd40, 32'h0000_0008, 32'h0000_0011, "R7 store after load");
    idle(2, "R7 hold");
    access(1, 6'd35, 32'h0000_0008, 32'h0, "R7 sees store");
    // R5 unaligned word accesses
    access(1, 6'd43, 32'h0000_000C, 32'hCAFE_F00D, "R5 base");
    access(1, 6'd35, 32'h0000_000C, 32'h0, "R5 load");
    access(1, 6'd43, 32'h0000_000E, 32'h0BAD_0BAD, "R5 sw off2");
    access(1, 6'd43, 32'h0000_000D, 32'h0BAD_0BAD, "R5 sw off1");
    access(1, 6'd35, 32'h0000_000F, 32'h0, "R5 lw off3");
    access(1, 6'd35, 32'h0000_000C, 32'h0, "R5 word intact");
    // R8 wrap modulo depth
    access(1, 6'd43, 32'h0000_0100 + 32'(4*DEPTH), 32'hA5A5_5A5A, "R8 store hi");
    access(1, 6'd35, 32'h0000_0100, 32'h0, "R8 load lo");
    access(1, 6'd32, 32'h0000_0103 + 32'(8*DEPTH), 32'h0, "R8 byte lo");
    // R9 ignored requests
    access(1, 6'd12, 32'h0000_0000, 32'hFFFF_FFFF, "R9 bad op");
    access(0, 6'd35, 32'h0000_0000, 32'h0, "R9 no req load");
    idle(1, "R9 no req store");
    access(1, 6'd35, 32'h0000_0000, 32'h0, "R9 word intact");
    idle(3, "R7 tail hold");

    while (q.size() > 0) @(posedge clk);
    #2;
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule